// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is the host-side controller for a 12-bit sampling converter that is read over a three-wire serial link. A frame begins when the block pulls the active-low chip select down. That edge also makes the converter sample its input. The block then toggles a serial clock derived from the system clock, 16 cycles by default, and shifts in the returned bits most significant first. When the frame is complete, it releases chip select and presents the 12-bit result with a one-cycle valid strobe. The frame word carries four leading zeros ahead of the data, and the block reports an error when any of the captured leading bits is set.

A frame is started by a one-shot request, or it repeats on its own while the free-running input is held. A programmable idle gap keeps chip select high between frames, with a floor set by a parameter, so that the converter always gets its quiet and acquisition time. Per-frame options, latched when chip select falls:
- The serial clock half-period, in system clocks.
- A longer 18-clock burst.
- Capture on rising serial-clock edges instead of falling ones, for slow links.

An abort input ends a frame early. The partial result is discarded.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is high and on the cycle after it, chip select and the serial clock are high and valid is low.
- R2: Chip select stays high until a start request or the free-running input is seen in idle. It falls on the following clock edge and stays low until the frame ends or is aborted.
- R3: The serial clock is high whenever chip select is high. After chip select falls, the serial clock stays high for H system clocks and then alternates low and high phases of H system clocks each, where H = max(half-period input, 1).
- R4: A frame has exactly 16 falling serial-clock edges, or 18 when the long-burst input is 1. Chip select and the serial clock rise together at the end of the last low phase.
- R5: With rising capture off, the data input is sampled as each of the 16 falling edges is issued. The first sample is the bit presented when chip select fell. Samples form the 16-bit frame word MSB first, and the result is its low 12 bits.
- R6: With rising capture on, the data input is sampled as each of rising edges 1 to 15 is issued. These samples form frame bits 14 down to 0, frame bit 15 is taken as 0, and the result is the low 12 bits.
- R7: The error output is 1 when any of frame bits 15 to 12 is 1, and 0 otherwise. This is updated with each valid result.
- R8: Valid is high for exactly one cycle, in the cycle in which chip select rises at the end of a complete frame. The result and error outputs hold their values until the next valid.
- R9: Abort high during a frame raises chip select and the serial clock on the next edge. No valid is issued for that frame and the result is unchanged.
- R10: After a frame ends or is aborted, chip select stays high for exactly G+1 system clocks before it can fall again, where G = max(gap input, MIN_GAP).
- R11: While the free-running input is held, frames follow one another without any start request, each separated by the R10 gap.
- R12: The data input is ignored during the two extra clocks of a long burst. The result depends only on the first 16 falling-edge samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame (taken in idle) |
| free_run_i | input | 1 | Run frames back to back while high |
| half_per_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| gap_i | input | GAP_W | Idle gap in system clocks (raised to MIN_GAP) |
| long_burst_i | input | 1 | Use an 18-clock frame instead of 16 |
| rise_cap_i | input | 1 | Capture on rising serial-clock edges |
| abort_i | input | 1 | Terminate the current frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, high when idle |
| result_o | output | DATA_W | Last valid conversion result |
| lead_err_o | output | 1 | Leading-zero error flag of the last result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check on every cycle the protocol properties that hold for any data:
- The serial clock is high whenever chip select is high.
- The idle state holds after reset.
- Valid is a single-cycle pulse that coincides with chip select rising.
- Valid never follows an abort.
- Every valid frame carried 16 or 18 falling edges.
- No chip-select fall comes sooner than the minimum gap.

Other properties need the bench's scenarios, which use a converter model and a scoreboard:
- The bit alignment of each capture mode.
- The leading-zero flag.
- The exact half-period and gap lengths.
- That the long-burst tail and aborted frames leave the result untouched.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;

  // Raise a programmed count to a floor.
  function automatic int unsigned floor_to(int unsigned val, int unsigned lo);
    return (val < lo) ? lo : val;
  endfunction

  // Falling-edge capture: the edge about to be issued is taken when fewer
  // than the frame's data edges have been issued so far.
  function automatic logic fall_takes(int unsigned issued, int unsigned frame_clks);
    return issued < frame_clks;
  endfunction

  // Rising-edge capture: rising edge k follows falling edge k; edges 1..N-1.
  function automatic logic rise_takes(int unsigned issued, int unsigned frame_clks);
    return (issued >= 1) && (issued < frame_clks);
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
module adc_seq_clkdiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == half_i - W'(1));
  assign tick_o = run_i && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
module adc_seq_capture #(
  parameter int FRAME_CLKS = 16,
  parameter int DATA_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] result_o,
  output logic              lead_err_o,
  output logic              valid_o
);

  logic [FRAME_CLKS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      sh_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[FRAME_CLKS-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      lead_err_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= commit_i;
      if (commit_i) begin
        result_o   <= sh_q[DATA_W-1:0];
        lead_err_o <= |sh_q[FRAME_CLKS-1:DATA_W];
      end
    end
  end

endmodule

// File: rtl/adc_seq_gap.sv
`timescale 1ns/1ps
module adc_seq_gap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);

  logic [W-1:0] len_q;
  logic [W-1:0] cnt_q;
  logic         active_q;

  assign done_o = active_q && (cnt_q == len_q - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= W'(1);
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      len_q    <= len_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (done_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/adc_read_seq.sv
`timescale 1ns/1ps
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int          DATA_W     = 12,
  parameter int          FRAME_CLKS = 16,
  parameter int          EXTRA_CLKS = 2,
  parameter int          DIV_W      = 8,
  parameter int          GAP_W      = 8,
  parameter int unsigned MIN_GAP    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              free_run_i,
  input  logic [DIV_W-1:0]  half_per_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              long_burst_i,
  input  logic              rise_cap_i,
  input  logic              abort_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              lead_err_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(FRAME_CLKS + EXTRA_CLKS + 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(FRAME_CLKS);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(FRAME_CLKS + EXTRA_CLKS);

  seq_state_t       state_q;
  logic             cs_n_q;
  logic             sclk_q;
  logic [CNT_W-1:0] fall_cnt_q;
  logic [DIV_W-1:0] half_q;
  logic             long_q;
  logic             rise_q;

  // Named internal events, used by the logic and by the bound checker.
  logic             in_frame;
  logic             start_evt;
  logic             abort_evt;
  logic             tick;
  logic             fall_evt;
  logic             rise_evt;
  logic             frame_done;
  logic             sample_en;
  logic             gap_done;
  logic [CNT_W-1:0] last_fall;
  logic [DIV_W-1:0] half_eff;
  logic [GAP_W-1:0] gap_eff;

  assign in_frame   = (state_q == ST_FRAME);
  assign start_evt  = (state_q == ST_IDLE) && (start_i || free_run_i);
  assign abort_evt  = in_frame && abort_i;
  assign fall_evt   = in_frame && !abort_i && tick && sclk_q;
  assign rise_evt   = in_frame && !abort_i && tick && !sclk_q;
  assign last_fall  = long_q ? LONG_END : SHORT_END;
  assign frame_done = rise_evt && (fall_cnt_q == last_fall);
  assign sample_en  = rise_q
                    ? (rise_evt && rise_takes(32'(fall_cnt_q), FRAME_CLKS))
                    : (fall_evt && fall_takes(32'(fall_cnt_q), FRAME_CLKS));
  assign half_eff   = DIV_W'(floor_to(32'(half_per_i), 1));
  assign gap_eff    = GAP_W'(floor_to(32'(gap_i), MIN_GAP));

  adc_seq_clkdiv #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run_i  (in_frame),
    .half_i (half_q),
    .tick_o (tick)
  );

  adc_seq_capture #(.FRAME_CLKS(FRAME_CLKS), .DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (start_evt),
    .shift_i    (sample_en),
    .bit_i      (sdata_i),
    .commit_i   (frame_done),
    .result_o   (result_o),
    .lead_err_o (lead_err_o),
    .valid_o    (valid_o)
  );

  adc_seq_gap #(.W(GAP_W)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .load_i (frame_done || abort_evt),
    .len_i  (gap_eff),
    .done_o (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cs_n_q     <= 1'b1;
      sclk_q     <= 1'b1;
      fall_cnt_q <= '0;
      half_q     <= DIV_W'(1);
      long_q     <= 1'b0;
      rise_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_evt) begin
            state_q    <= ST_FRAME;
            cs_n_q     <= 1'b0;
            fall_cnt_q <= '0;
            half_q     <= half_eff;
            long_q     <= long_burst_i;
            rise_q     <= rise_cap_i;
          end
        end
        ST_FRAME: begin
          if (abort_evt || frame_done) begin
            state_q <= ST_GAP;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b1;
          end else if (fall_evt) begin
            sclk_q     <= 1'b0;
            fall_cnt_q <= fall_cnt_q + CNT_W'(1);
          end else if (rise_evt) begin
            sclk_q <= 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;

endmodule

// File: rtl/adc_read_seq_chk.sv
`timescale 1ns/1ps
module adc_read_seq_chk #(
  parameter int          FRAME_CLKS = 16,
  parameter int          EXTRA_CLKS = 2,
  parameter int unsigned MIN_GAP    = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o,
  input logic abort_evt,
  input logic frame_done
);

  logic        rst_d;
  logic        cs_d;
  logic        sclk_d;
  logic [7:0]  falls_q;
  logic [15:0] hi_q;
  logic        seen_low_q;

  always_ff @(posedge clk) begin
    rst_d  <= rst;
    cs_d   <= cs_n_o;
    sclk_d <= sclk_o;
    if (rst) begin
      falls_q    <= '0;
      hi_q       <= '0;
      seen_low_q <= 1'b0;
    end else begin
      if (cs_d && !cs_n_o) begin
        falls_q <= '0;
      end else if (!cs_n_o && sclk_d && !sclk_o) begin
        falls_q <= falls_q + 8'd1;
      end
      if (cs_n_o) begin
        if (hi_q != 16'hFFFF) hi_q <= hi_q + 16'd1;
      end else begin
        hi_q       <= '0;
        seen_low_q <= 1'b1;
      end
    end
  end

  // R1: idle outputs on the cycle after reset
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_idle: assert (cs_n_o && sclk_o && !valid_o)
        else $error("R1 outputs not idle after reset");
    end
  end

  a_r3_sclk_high_when_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r8_valid_with_cs_rise: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cs_n_o && !cs_d));

  a_r4_done_releases_cs: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (cs_n_o && sclk_o && valid_o));

  a_r4_edge_count: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (falls_q == 8'(FRAME_CLKS) || falls_q == 8'(FRAME_CLKS + EXTRA_CLKS)));

  a_r9_abort_no_valid: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (!valid_o && cs_n_o));

  a_r10_min_gap: assert property (@(posedge clk) disable iff (rst)
    (cs_d && !cs_n_o && seen_low_q) |-> (hi_q >= 16'(MIN_GAP + 1)));

endmodule

bind adc_read_seq adc_read_seq_chk #(
  .FRAME_CLKS(FRAME_CLKS),
  .EXTRA_CLKS(EXTRA_CLKS),
  .MIN_GAP   (MIN_GAP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .valid_o    (valid_o),
  .abort_evt  (abort_evt),
  .frame_done (frame_done)
);

// File: tb/adc_read_seq_tb_top.sv
`timescale 1ns/1ps
module adc_read_seq_tb_top;

  localparam int MIN_G = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, free_run_i, long_burst_i, rise_cap_i, abort_i;
  logic [7:0]  half_per_i, gap_i;
  logic        sdata_i = 1'b0;
  logic        cs_n_o, sclk_o, lead_err_o, valid_o;
  logic [11:0] result_o;

  always #2.5 clk = ~clk;

  adc_read_seq #(.MIN_GAP(MIN_G)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .free_run_i(free_run_i),
    .half_per_i(half_per_i), .gap_i(gap_i), .long_burst_i(long_burst_i),
    .rise_cap_i(rise_cap_i), .abort_i(abort_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
    .lead_err_o(lead_err_o), .valid_o(valid_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Converter model: word bit 15 appears at chip-select fall, each later bit
  // after a falling serial-clock edge; ones after the word is exhausted.
  logic [15:0] adc_q[$];
  logic [15:0] adc_word;
  int          adc_idx;

  always @(negedge cs_n_o) begin
    adc_word = (adc_q.size() > 0) ? adc_q.pop_front() : 16'hFFFF;
    adc_idx  = 15;
    sdata_i  = adc_word[15];
  end

  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      adc_idx = adc_idx - 1;
      sdata_i = (adc_idx >= 0) ? adc_word[adc_idx] : 1'b1;
    end
  end

  // Scoreboard
  typedef struct packed { logic [11:0] res; logic err; logic rise; } exp_t;
  exp_t exp_q[$];
  int   vals_seen = 0;

  always @(negedge clk) begin
    if (rst === 1'b0 && valid_o === 1'b1) begin
      vals_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R9 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(result_o == e.res, e.rise ? "R6 result" : "R5 result", result_o, e.res);
        chk(lead_err_o == e.err, "R7 lead error", lead_err_o, e.err);
      end
    end
  end

  // Frame timing monitor
  int  hi_lead, low1, nfall, hi_run, last_gap;
  bit  seen_fall;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    if (cs_n_o === 1'b0) begin
      if (prev_cs) begin
        last_gap  = hi_run;
        hi_run    = 0;
        hi_lead   = 1;
        nfall     = 0;
        low1      = 0;
        seen_fall = 1'b0;
      end else if (!seen_fall && sclk_o) begin
        hi_lead++;
      end
      if (!sclk_o && prev_sclk) begin
        nfall++;
        seen_fall = 1'b1;
      end
      if (!sclk_o && nfall == 1) low1++;
    end else begin
      hi_run++;
    end
    prev_cs   = cs_n_o;
    prev_sclk = sclk_o;
  end

  // Driver: queue converter word and expected result, then request a frame.
  task automatic run_frame(input logic [15:0] w);
    exp_t e;
    adc_q.push_back(w);
    e.res  = w[11:0];
    e.err  = rise_cap_i ? (|w[14:12]) : (|w[15:12]);
    e.rise = rise_cap_i;
    exp_q.push_back(e);
    start_i = 1'b1;
    do @(negedge clk); while (cs_n_o);
    start_i = 1'b0;
    do @(negedge clk); while (!cs_n_o);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] held;
    int base;
    rst = 1'b1; start_i = 0; free_run_i = 0; abort_i = 0;
    long_burst_i = 0; rise_cap_i = 0; half_per_i = 8'd2; gap_i = 8'd0;
    repeat (4) @(negedge clk);
    chk(cs_n_o && sclk_o && !valid_o, "R1 during reset", {cs_n_o, sclk_o, valid_o}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o && sclk_o && !valid_o, "R1 after reset", {cs_n_o, sclk_o, valid_o}, 3'b110);
    repeat (10) @(negedge clk);
    chk(cs_n_o == 1'b1, "R2 no frame without request", cs_n_o, 1);

    // Falling capture, H=2
    run_frame(16'h0ABC);
    chk(hi_lead == 2, "R3 lead high phase", hi_lead, 2);
    chk(low1 == 2, "R3 low phase", low1, 2);
    chk(nfall == 16, "R4 falling edges", nfall, 16);
    chk(!valid_o && result_o == 12'hABC, "R8 held after pulse", result_o, 12'hABC);
    run_frame(16'h1555);   // R7 leading one
    run_frame(16'h0F00);

    // Half-period 0 acts as 1
    half_per_i = 8'd0;
    run_frame(16'h0001);
    chk(hi_lead == 1 && low1 == 1, "R3 minimum half period", {hi_lead[3:0], low1[3:0]}, 8'h11);

    // Long burst: extra clocks see ones, result unaffected
    long_burst_i = 1'b1; half_per_i = 8'd1;
    run_frame(16'h0123);   // R12
    chk(nfall == 18, "R4 long burst edges", nfall, 18);
    long_burst_i = 1'b0;

    // Rising capture: bit 15 ignored
    rise_cap_i = 1'b1; half_per_i = 8'd3;
    run_frame(16'h8A5A);   // R6 err 0
    run_frame(16'h2F0F);   // R6 err 1
    rise_cap_i = 1'b0; half_per_i = 8'd2;

    // Abort, then a frame after the minimum gap
    held = result_o;
    adc_q.push_back(16'h0FFF);
    start_i = 1'b1;
    do @(negedge clk); while (cs_n_o);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(cs_n_o && sclk_o, "R9 abort releases lines", {cs_n_o, sclk_o}, 2'b11);
    chk(result_o == held, "R9 result kept on abort", result_o, held);
    run_frame(16'h0321);
    chk(last_gap == MIN_G + 1, "R10 gap after abort", last_gap, MIN_G + 1);

    // Free running with programmed gap
    repeat (20) @(negedge clk);
    gap_i = 8'd10;
    for (int i = 0; i < 3; i++) begin
      exp_t e;
      adc_q.push_back(16'h0100 + 16'(i * 16'h111));
      e.res = 12'h100 + 12'(i * 12'h111); e.err = 1'b0; e.rise = 1'b0;
      exp_q.push_back(e);
    end
    base = vals_seen;
    free_run_i = 1'b1;
    while (vals_seen < base + 3) @(negedge clk);
    free_run_i = 1'b0;
    chk(vals_seen == base + 3, "R11 free-run frames", vals_seen - base, 3);
    chk(last_gap == 11, "R10 programmed gap", last_gap, 11);

    // Free running with gap below the floor
    repeat (20) @(negedge clk);
    gap_i = 8'd2;
    for (int i = 0; i < 2; i++) begin
      exp_t e;
      adc_q.push_back(16'h0777);
      e.res = 12'h777; e.err = 1'b0; e.rise = 1'b0;
      exp_q.push_back(e);
    end
    base = vals_seen;
    free_run_i = 1'b1;
    while (vals_seen < base + 2) @(negedge clk);
    free_run_i = 1'b0;
    chk(last_gap == MIN_G + 1, "R10 gap floor", last_gap, MIN_G + 1);

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    chk(cs_n_o == 1'b1, "R11 stops when released", cs_n_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule